// File: doc/BRIEF.md
# Free-Slot Pointer and Record Allocator

This block keeps one occupancy tag per word of a word-parallel associative array and turns that tag set into a stream of write addresses for new records. A search command takes a snapshot of the response flags. A word responds when its tag is 0, which is the same as an exact-match search for zero on the tag. A lowest-address-first priority encoder then presents the first responder as a registered pointer.

Each allocate strobe does three things in one cycle. It issues a record write at the pointer, sets that word's tag to 1 and drops that word's response flag. The pointer therefore moves to the next higher free word on the following cycle. A batch of records can be stored at one record per clock. When no responder is left, the pointer becomes invalid and a no-free-slot flag is raised for the exception handler. A delete clears the tag of a named word. That word becomes visible again only at the next search.

Top module: `slot_alloc_ptr`

## Requirements
- R1: After reset, every word is free, `ptr_valid_o`, `no_free_o` and `wr_en_o` are 0, and no search has yet taken place.
- R2: One cycle after `search_i`, the response set holds exactly the words whose tag is 0. `ptr_valid_o` is 1 and `ptr_addr_o` names the lowest-addressed of them.
- R3: An `alloc_i` accepted while `ptr_valid_o` is 1 gives `wr_en_o`=1 with `wr_addr_o` equal to the pointer on the next cycle, and sets that word's tag to 1.
- R4: Without a search, the cycle after an accepted allocate shows the next higher-addressed responder. Allocates can be issued on consecutive cycles. Without search or accepted allocate, the pointer holds.
- R5: Once a search has taken place and no responder remains, `ptr_valid_o` is 0 and `no_free_o` is 1. Both never hold at the same time.
- R6: `alloc_i` while `ptr_valid_o` is 0 is ignored: `wr_en_o` stays 0 and no tag changes.
- R7: `del_i` clears the tag of word `del_addr_i` without changing the pointer or the current responders. The word responds again from the next search.
- R8: `search_i` together with an accepted `alloc_i` writes at the old pointer first. The new response set treats that word as occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| search_i | input | 1 | Capture the free words as the new response set |
| alloc_i | input | 1 | Store a record at the pointer |
| del_i | input | 1 | Release a word |
| del_addr_i | input | AW | Word to release |
| ptr_valid_o | output | 1 | A free responder is pointed at |
| ptr_addr_o | output | AW | Lowest-addressed remaining responder |
| no_free_o | output | 1 | Search done and no responder remains |
| wr_en_o | output | 1 | Record write strobe to the array |
| wr_addr_o | output | AW | Word address of the record write |

## Verification
Two functions can fall in the same cycle: a fresh search and the consumption of the current slot. The bench frees two words and searches, which points at the lower one. It then raises search and allocate together. It expects the write at that word, and on the next cycle a pointer at the higher freed word, not at the word just written. A release issued in the middle of a batch is judged the same way. The pointer must hold until a later search brings the word back.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;
  localparam int unsigned SLOT_WORDS_DEF = 256;

  typedef enum logic [1:0] {
    TAG_KEEP  = 2'd0,
    TAG_CLEAR = 2'd1,
    TAG_SET   = 2'd2
  } tag_op_e;

  function automatic tag_op_e tag_op(input logic set_hit, input logic clr_hit);
    if (set_hit)      return TAG_SET;
    else if (clr_hit) return TAG_CLEAR;
    else              return TAG_KEEP;
  endfunction
endpackage

// File: rtl/slot_alloc_tags.sv
module slot_alloc_tags
  import slot_alloc_pkg::*;
#(
  parameter int unsigned WORDS = SLOT_WORDS_DEF,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [AW-1:0]    set_addr,
  input  logic             clr_en,
  input  logic [AW-1:0]    clr_addr,
  output logic [WORDS-1:0] tag_next
);
  logic [WORDS-1:0] tag_q;

  for (genvar w = 0; w < WORDS; w++) begin : g_tag
    tag_op_e op;
    assign op = tag_op(set_en && (set_addr == AW'(w)), clr_en && (clr_addr == AW'(w)));
    always_comb begin
      case (op)
        TAG_SET:   tag_next[w] = 1'b1;
        TAG_CLEAR: tag_next[w] = 1'b0;
        default:   tag_next[w] = tag_q[w];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tag_q <= '0;
    else     tag_q <= tag_next;
  end
endmodule

// File: rtl/slot_alloc_resp.sv
module slot_alloc_resp #(
  parameter int unsigned WORDS = 256,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WORDS-1:0] tag_next,
  input  logic             take,
  input  logic [AW-1:0]    take_addr,
  output logic [WORDS-1:0] resp_next
);
  logic [WORDS-1:0] resp_q;

  always_comb begin
    if (load) begin
      resp_next = ~tag_next;
    end else begin
      resp_next = resp_q;
      if (take) resp_next[take_addr] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) resp_q <= '0;
    else     resp_q <= resp_next;
  end
endmodule

// File: rtl/slot_alloc_penc.sv
module slot_alloc_penc #(
  parameter int unsigned WORDS = 256,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic [WORDS-1:0] req,
  output logic             any,
  output logic [AW-1:0]    first
);
  always_comb begin
    any   = |req;
    first = '0;
    for (int i = WORDS - 1; i >= 0; i--) begin
      if (req[i]) first = AW'(i);
    end
  end
endmodule

// File: rtl/slot_alloc_ptr.sv
module slot_alloc_ptr
  import slot_alloc_pkg::*;
#(
  parameter int unsigned WORDS = SLOT_WORDS_DEF,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          search_i,
  input  logic          alloc_i,
  input  logic          del_i,
  input  logic [AW-1:0] del_addr_i,
  output logic          ptr_valid_o,
  output logic [AW-1:0] ptr_addr_o,
  output logic          no_free_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o
);
  logic             take;
  logic [WORDS-1:0] tag_next;
  logic [WORDS-1:0] resp_next;
  logic             enc_any;
  logic [AW-1:0]    enc_first;
  logic             searched_q;

  assign take = alloc_i && ptr_valid_o;

  slot_alloc_tags #(.WORDS(WORDS)) u_tags (
    .clk(clk), .rst(rst),
    .set_en(take), .set_addr(ptr_addr_o),
    .clr_en(del_i), .clr_addr(del_addr_i),
    .tag_next(tag_next)
  );

  slot_alloc_resp #(.WORDS(WORDS)) u_resp (
    .clk(clk), .rst(rst),
    .load(search_i), .tag_next(tag_next),
    .take(take), .take_addr(ptr_addr_o),
    .resp_next(resp_next)
  );

  slot_alloc_penc #(.WORDS(WORDS)) u_penc (
    .req(resp_next), .any(enc_any), .first(enc_first)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_valid_o <= 1'b0;
      ptr_addr_o  <= '0;
      no_free_o   <= 1'b0;
      wr_en_o     <= 1'b0;
      wr_addr_o   <= '0;
      searched_q  <= 1'b0;
    end else begin
      ptr_valid_o <= enc_any;
      ptr_addr_o  <= enc_first;
      no_free_o   <= (search_i || searched_q) && !enc_any;
      wr_en_o     <= take;
      if (take) wr_addr_o <= ptr_addr_o;
      if (search_i) searched_q <= 1'b1;
    end
  end
endmodule

// File: rtl/slot_alloc_ptr_chk.sv
module slot_alloc_ptr_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          search_i,
  input logic          alloc_i,
  input logic          ptr_valid_o,
  input logic [AW-1:0] ptr_addr_o,
  input logic          no_free_o,
  input logic          wr_en_o,
  input logic [AW-1:0] wr_addr_o
);
  p_write_at_ptr_r3: assert property (@(posedge clk) disable iff (rst)
    (alloc_i && ptr_valid_o) |=> (wr_en_o && wr_addr_o == $past(ptr_addr_o)));

  p_ignore_invalid_r6: assert property (@(posedge clk) disable iff (rst)
    !(alloc_i && ptr_valid_o) |=> !wr_en_o);

  p_ascend_r4: assert property (@(posedge clk) disable iff (rst)
    (alloc_i && ptr_valid_o && !search_i) |=> (!ptr_valid_o || ptr_addr_o > $past(ptr_addr_o)));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!search_i && !(alloc_i && ptr_valid_o)) |=> ($stable(ptr_valid_o) && $stable(ptr_addr_o)));

  p_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(ptr_valid_o && no_free_o));
endmodule

bind slot_alloc_ptr slot_alloc_ptr_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .search_i(search_i), .alloc_i(alloc_i),
  .ptr_valid_o(ptr_valid_o), .ptr_addr_o(ptr_addr_o), .no_free_o(no_free_o),
  .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o)
);

// File: tb/slot_alloc_ptr_test.sv
module slot_alloc_ptr_test;
  localparam int unsigned WORDS = 256;
  localparam int unsigned AW = $clog2(WORDS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic search_i = 1'b0, alloc_i = 1'b0, del_i = 1'b0;
  logic [AW-1:0] del_addr_i = '0;
  logic ptr_valid_o, no_free_o, wr_en_o;
  logic [AW-1:0] ptr_addr_o, wr_addr_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  slot_alloc_ptr #(.WORDS(WORDS)) uut (
    .clk(clk), .rst(rst), .search_i(search_i), .alloc_i(alloc_i),
    .del_i(del_i), .del_addr_i(del_addr_i),
    .ptr_valid_o(ptr_valid_o), .ptr_addr_o(ptr_addr_o), .no_free_o(no_free_o),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_search();
    search_i = 1'b1; step(); search_i = 1'b0;
  endtask

  task automatic do_delete(input int a);
    del_i = 1'b1; del_addr_i = AW'(a); step(); del_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "ptr_valid", ptr_valid_o, 0);
    chk("R1", "no_free", no_free_o, 0);
    chk("R1", "wr_en", wr_en_o, 0);
  endtask

  task automatic t_first_search();
    do_search();
    chk("R2", "valid after search", ptr_valid_o, 1);
    chk("R2", "lowest free", ptr_addr_o, 0);
  endtask

  task automatic t_batch();
    alloc_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R3", "wr_en", wr_en_o, 1);
      chk("R3", "wr_addr", wr_addr_o, k);
      chk("R4", "next ptr", ptr_addr_o, k + 1);
    end
    alloc_i = 1'b0;
    step();
    chk("R4", "wr_en idle", wr_en_o, 0);
    chk("R4", "ptr holds", ptr_addr_o, 3);
  endtask

  task automatic t_delete_mid();
    do_delete(1);
    chk("R7", "ptr unchanged by delete", ptr_addr_o, 3);
    chk("R7", "valid unchanged", ptr_valid_o, 1);
    do_search();
    chk("R7", "freed word responds", ptr_addr_o, 1);
  endtask

  task automatic t_fill();
    int n = 0;
    alloc_i = 1'b1;
    while (ptr_valid_o) begin
      step();
      if (wr_en_o) n++;
    end
    alloc_i = 1'b0;
    chk("R4", "writes to fill", n, WORDS - 2);
    chk("R5", "ptr_valid when full", ptr_valid_o, 0);
    chk("R5", "no_free when full", no_free_o, 1);
  endtask

  task automatic t_alloc_ignored();
    alloc_i = 1'b1; step(); alloc_i = 1'b0;
    chk("R6", "no write without pointer", wr_en_o, 0);
    do_search();
    chk("R6", "still full after ignored alloc", ptr_valid_o, 0);
    chk("R5", "no_free after search", no_free_o, 1);
  endtask

  task automatic t_search_and_alloc();
    do_delete(200);
    do_delete(77);
    do_search();
    chk("R2", "lowest of freed", ptr_addr_o, 77);
    chk("R5", "no_free cleared", no_free_o, 0);
    search_i = 1'b1; alloc_i = 1'b1; step();
    search_i = 1'b0; alloc_i = 1'b0;
    chk("R8", "write at old ptr", wr_addr_o, 77);
    chk("R8", "wr_en", wr_en_o, 1);
    chk("R8", "search skips written word", ptr_addr_o, 200);
    alloc_i = 1'b1; step(); alloc_i = 1'b0;
    chk("R3", "last write", wr_addr_o, 200);
    chk("R5", "exhausted valid", ptr_valid_o, 0);
    chk("R5", "exhausted no_free", no_free_o, 1);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_first_search();
    t_batch();
    t_delete_mid();
    t_fill();
    t_alloc_ignored();
    t_search_and_alloc();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule